// File: doc/BRIEF.md
# Line Activation Sequencer with Host Debug Override

This block steps a line transceiver through its activation sequence. It keeps a 7-bit activation state and a timeout timer. In normal operation the state advances by itself on each baud boundary while an advance-condition input is high. It falls back to idle when a deactivate request arrives or when the timer runs out. The real activation conditions and the error-power measurement are computed outside the block and arrive as plain inputs.

A host writes an 8-bit control word. With it the host can freeze the state, step it once, preload it with any value, take over from the autonomous sequencer, or stop the timer. Every host action on the state waits for the next baud boundary. A read port returns the external monitor word by default. When the readback-select input is high, it returns the control settings instead. The low six state bits count the sequence position, which saturates at a final "link up" position. Bit 6 is a sticky warm-start flag: 0 means cold start, 1 means warm start.

Top module: `act_seq_top`

## Requirements
- R1: A hardware reset (rst_n low) or a one-cycle sw_rst pulse clears the control word, the state (to 0, cold start) and the expire flag. A sw_rst pulse does not restart the baud or timer dividers.
- R2: The control word bit map is: bit 7 steer, bit 6 interpolator enable, bit 5 load, bit 4 step, bit 3 hold, bit 2 timer disable, bits 1:0 reserved. A 0-to-1 change of bit 5 captures host_preset, and the captured value becomes the state at the next baud tick. While bit 5 stays 1 no further load happens. The state never changes between baud ticks.
- R3: A 0-to-1 change of bit 4 requests one step. At the next baud tick the state takes its next value if adv_cond is high; otherwise the request is dropped. While bit 4 stays 1 no further step happens.
- R4: At a baud tick a load beats a step, and a step beats hold. With hold set and no load or step, the state stays unchanged.
- R5: With steer 0 and hold 0, at each baud tick deact returns the state to position 0 with bit 6 kept; otherwise adv_cond moves the state to its next value. With steer 1 the state never changes on its own.
- R6: The next value increments bits 5:0 and saturates at ACT_FINAL. Reaching ACT_FINAL sets bit 6, and bit 6 then stays set until a reset or a load.
- R7: While bits 5:0 lie strictly between 0 and ACT_FINAL and the timer is enabled, the timer counts timer ticks. After TMO_TICKS ticks it sets tmr_expired. The flag clears once the state leaves that range.
- R8: With steer 0 and hold 0, an expired timer sends the state to position 0 (bit 6 kept) at the next baud tick.
- R9: With control bit 2 set, tmr_expired reads 0 and the count restarts from zero.
- R10: rd_data equals monitor_in when rd_sel is 0. When rd_sel is 1, it equals the control word, with bits 1:0 reading 0.
- R11: interp_en is 1 exactly when control bits 7 and 6 are both 1 and lt_mode is 1.
- R12: baud_tick is high for one clock in every BAUD_DIV clocks. A timer tick occurs once every TMR_DIV baud ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset pulse |
| host_wr | input | 1 | Control word write strobe |
| host_wdata | input | 8 | Control word write data |
| host_preset | input | 7 | State value for a host load |
| rd_sel | input | 1 | Readback select: 1 returns control word |
| monitor_in | input | 8 | External monitor word |
| adv_cond | input | 1 | Condition to move to the next position |
| deact | input | 1 | Deactivate request |
| lt_mode | input | 1 | Line-terminal mode |
| rd_data | output | 8 | Read data |
| act_state | output | 7 | Current activation state |
| tmr_expired | output | 1 | Timer expire flag |
| interp_en | output | 1 | Timing interpolator enable |
| baud_tick | output | 1 | Baud boundary strobe |

## Verification
The assertions assume that rst_n is released synchronously and that sw_rst is a pulse aligned to the clock. They also assume that host_preset, adv_cond and deact are settled before each clock edge. The stimulus changes every input just after a rising edge, holds host_wr high for exactly one cycle per write, and opens each load or step with a separate write that clears its bit. It uses short divider and timeout values so that the timeout, the saturation at the final position and the warm-flag persistence are all reached within a few hundred cycles.

// File: rtl/act_pkg.sv
package act_pkg;

  typedef struct packed {
    logic       steer;
    logic       interp;
    logic       load;
    logic       step;
    logic       hold;
    logic       tmr_dis;
    logic [1:0] rsvd;
  } act_ctl_t;

  // Next sequence position: bits 5:0 count up and saturate at fin;
  // bit 6 becomes set when fin is reached and is never cleared here.
  function automatic logic [6:0] act_next(input logic [6:0] s, input logic [5:0] fin);
    logic [5:0] lo;
    lo = s[5:0];
    if (lo >= fin) begin
      return s;
    end
    lo = lo + 6'd1;
    return {s[6] | (lo == fin), lo};
  endfunction

endpackage

// File: rtl/act_tick_gen.sv
module act_tick_gen #(
  parameter int BAUD_DIV = 96,
  parameter int TMR_DIV  = 80
) (
  input  logic clk,
  input  logic rst_n,
  output logic baud_tick,
  output logic tmr_tick
);
  localparam int BW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int PW = (TMR_DIV > 1) ? $clog2(TMR_DIV) : 1;

  logic [BW-1:0] bcnt_q, bcnt_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pre_wrap;

  assign baud_tick = (bcnt_q == BW'(BAUD_DIV - 1));
  assign pre_wrap  = (pcnt_q == PW'(TMR_DIV - 1));
  assign tmr_tick  = baud_tick & pre_wrap;

  always_comb begin
    bcnt_d = baud_tick ? '0 : bcnt_q + BW'(1);
    pcnt_d = pcnt_q;
    if (baud_tick) begin
      pcnt_d = pre_wrap ? '0 : pcnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      bcnt_q <= bcnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  generate
    if (BAUD_DIV > 1) begin : g_gap_chk
      // R12: a baud strobe is never two clocks wide
      p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick)
        else $error("baud tick lasted more than one clock");
    end
  endgenerate

endmodule

// File: rtl/act_host_ctl.sv
module act_host_ctl
  import act_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic [6:0] preset_in,
  input  logic       rd_sel,
  input  logic [7:0] monitor_in,
  input  logic       lt_mode,
  input  logic       baud_tick,
  output logic [7:0] rd_data,
  output logic       interp_en,
  output logic       load_go,
  output logic [6:0] load_val,
  output logic       step_go,
  output logic       hold,
  output logic       steer,
  output logic       tmr_dis
);
  act_ctl_t   ctl_q, ctl_d;
  logic       larm_q, larm_d, sarm_q, sarm_d;
  logic       lpend_q, lpend_d, spend_q, spend_d;
  logic [6:0] lval_q, lval_d;
  logic       load_req, step_req;

  assign load_req = ctl_q.load & larm_q;
  assign step_req = ctl_q.step & sarm_q;

  assign load_go  = lpend_q | load_req;
  assign load_val = load_req ? preset_in : lval_q;
  assign step_go  = spend_q | step_req;
  assign hold     = ctl_q.hold;
  assign steer    = ctl_q.steer;
  assign tmr_dis  = ctl_q.tmr_dis;

  assign rd_data   = rd_sel ? ctl_q : monitor_in;
  assign interp_en = ctl_q.steer & ctl_q.interp & lt_mode;

  always_comb begin
    ctl_d   = ctl_q;
    larm_d  = ~ctl_q.load;
    sarm_d  = ~ctl_q.step;
    lpend_d = baud_tick ? 1'b0 : (lpend_q | load_req);
    spend_d = baud_tick ? 1'b0 : (spend_q | step_req);
    lval_d  = load_req ? preset_in : lval_q;
    if (wr_en) begin
      ctl_d      = act_ctl_t'(wdata);
      ctl_d.rsvd = 2'b00;
    end
    if (sw_rst) begin
      ctl_d   = '0;
      larm_d  = 1'b1;
      sarm_d  = 1'b1;
      lpend_d = 1'b0;
      spend_d = 1'b0;
      lval_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      larm_q  <= 1'b1;
      sarm_q  <= 1'b1;
      lpend_q <= 1'b0;
      spend_q <= 1'b0;
      lval_q  <= '0;
    end else begin
      ctl_q   <= ctl_d;
      larm_q  <= larm_d;
      sarm_q  <= sarm_d;
      lpend_q <= lpend_d;
      spend_q <= spend_d;
      lval_q  <= lval_d;
    end
  end

  // R2: an accepted load request is not accepted again on the next clock
  p_load_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !sw_rst) |=> !load_req)
    else $error("load accepted twice");

  // R3: same edge rule for step
  p_step_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !sw_rst) |=> !step_req)
    else $error("step accepted twice");

  // R10: reserved bits never read back as 1
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> (rd_data[1:0] == 2'b00))
    else $error("reserved control bits read as 1");

endmodule

// File: rtl/act_state_core.sv
module act_state_core
  import act_pkg::*;
#(
  parameter int ACT_FINAL = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       baud_tick,
  input  logic       load_go,
  input  logic [6:0] load_val,
  input  logic       step_go,
  input  logic       hold,
  input  logic       steer,
  input  logic       adv_cond,
  input  logic       deact,
  input  logic       expired,
  output logic [6:0] state_q
);
  localparam logic [5:0] FIN = 6'(ACT_FINAL);

  logic [6:0] state_d;
  logic [6:0] succ;

  assign succ = act_next(state_q, FIN);

  always_comb begin
    state_d = state_q;
    if (baud_tick) begin
      if (load_go) begin
        state_d = load_val;
      end else if (step_go) begin
        if (adv_cond) state_d = succ;
      end else if (hold) begin
        state_d = state_q;
      end else if (!steer) begin
        if (deact || expired) state_d = {state_q[6], 6'd0};
        else if (adv_cond)    state_d = succ;
      end
    end
    if (sw_rst) state_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  // R2: the state only moves on a baud boundary (or a software reset)
  p_baud_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !sw_rst) |=> $stable(state_q))
    else $error("state changed between baud ticks");

  // R4: hold freezes the state when no load or step is due
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && hold && !load_go && !step_go && !sw_rst) |=> $stable(state_q))
    else $error("state moved under hold");

  // R3: a step with the advance condition low leaves the state alone
  p_step_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && step_go && !load_go && !adv_cond && !sw_rst) |=> $stable(state_q))
    else $error("step advanced without condition");

  // R6: the warm flag persists except through reset or load
  p_warm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[6] && !sw_rst && !(baud_tick && load_go)) |=> state_q[6])
    else $error("warm flag lost");

endmodule

// File: rtl/act_timeout.sv
module act_timeout #(
  parameter int TMO_TICKS = 15000,
  parameter int ACT_FINAL = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       tmr_tick,
  input  logic       tmr_dis,
  input  logic [5:0] pos,
  output logic       expired
);
  localparam int         CW  = (TMO_TICKS > 1) ? $clog2(TMO_TICKS + 1) : 1;
  localparam logic [5:0] FIN = 6'(ACT_FINAL);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          active;

  assign active  = (pos != 6'd0) && (pos < FIN);
  assign expired = exp_q;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (sw_rst || tmr_dis || !active) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (tmr_tick && !exp_q) begin
      if (cnt_q == CW'(TMO_TICKS - 1)) begin
        exp_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  // R9: disabling the timer forces the flag low on the next clock
  p_dis_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_dis |=> !expired)
    else $error("expire set while timer disabled");

  // R7: an idle position clears the flag
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == 6'd0) |=> !expired)
    else $error("expire survived idle");

  // R7: the flag only rises on a timer tick
  p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_tick && !expired) |=> !expired)
    else $error("expire rose without a tick");

endmodule

// File: rtl/act_seq_top.sv
module act_seq_top
  import act_pkg::*;
#(
  parameter int BAUD_DIV  = 96,
  parameter int TMR_DIV   = 80,
  parameter int TMO_TICKS = 15000,
  parameter int ACT_FINAL = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic [6:0] host_preset,
  input  logic       rd_sel,
  input  logic [7:0] monitor_in,
  input  logic       adv_cond,
  input  logic       deact,
  input  logic       lt_mode,
  output logic [7:0] rd_data,
  output logic [6:0] act_state,
  output logic       tmr_expired,
  output logic       interp_en,
  output logic       baud_tick
);
  logic       tmr_tick;
  logic       load_go, step_go, hold, steer, tmr_dis;
  logic [6:0] load_val;
  logic [6:0] state;

  act_tick_gen #(.BAUD_DIV(BAUD_DIV), .TMR_DIV(TMR_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tmr_tick  (tmr_tick)
  );

  act_host_ctl u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .wr_en      (host_wr),
    .wdata      (host_wdata),
    .preset_in  (host_preset),
    .rd_sel     (rd_sel),
    .monitor_in (monitor_in),
    .lt_mode    (lt_mode),
    .baud_tick  (baud_tick),
    .rd_data    (rd_data),
    .interp_en  (interp_en),
    .load_go    (load_go),
    .load_val   (load_val),
    .step_go    (step_go),
    .hold       (hold),
    .steer      (steer),
    .tmr_dis    (tmr_dis)
  );

  act_state_core #(.ACT_FINAL(ACT_FINAL)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .baud_tick (baud_tick),
    .load_go   (load_go),
    .load_val  (load_val),
    .step_go   (step_go),
    .hold      (hold),
    .steer     (steer),
    .adv_cond  (adv_cond),
    .deact     (deact),
    .expired   (tmr_expired),
    .state_q   (state)
  );

  act_timeout #(.TMO_TICKS(TMO_TICKS), .ACT_FINAL(ACT_FINAL)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst   (sw_rst),
    .tmr_tick (tmr_tick),
    .tmr_dis  (tmr_dis),
    .pos      (state[5:0]),
    .expired  (tmr_expired)
  );

  assign act_state = state;

  // R1: a software reset returns the state to cold idle
  p_swrst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (act_state == 7'd0 && !tmr_expired))
    else $error("software reset left state");

endmodule

// File: tb/act_seq_top_tb.sv
module act_seq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BAUD_DIV   = 4;
  localparam int TMR_DIV    = 2;
  localparam int TMO_TICKS  = 3;
  localparam int FIN        = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_rst = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [6:0] host_preset = 7'h00;
  logic       rd_sel = 1'b0;
  logic [7:0] monitor_in = 8'h00;
  logic       adv_cond = 1'b0;
  logic       deact = 1'b0;
  logic       lt_mode = 1'b0;
  logic [7:0] rd_data;
  logic [6:0] act_state;
  logic       tmr_expired;
  logic       interp_en;
  logic       baud_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  act_seq_top #(.BAUD_DIV(BAUD_DIV), .TMR_DIV(TMR_DIV), .TMO_TICKS(TMO_TICKS),
                .ACT_FINAL(FIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_preset(host_preset), .rd_sel(rd_sel),
    .monitor_in(monitor_in), .adv_cond(adv_cond), .deact(deact), .lt_mode(lt_mode),
    .rd_data(rd_data), .act_state(act_state), .tmr_expired(tmr_expired),
    .interp_en(interp_en), .baud_tick(baud_tick)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic logic [6:0] ref_next(input logic [6:0] s);
    logic [5:0] lo;
    lo = s[5:0];
    if (lo >= 6'(FIN)) return s;
    return {s[6] || ((lo + 6'd1) == 6'(FIN)), lo + 6'd1};
  endfunction

  int         m_bc, m_pc, m_tc;
  logic [7:0] m_ctl;
  logic [6:0] m_st, m_lv;
  bit         m_larm, m_sarm, m_lp, m_sp, m_exp;

  always @(posedge clk) begin : model
    bit         bt, tt, lreq, sreq, lgo, sgo;
    logic [6:0] lval, ns;
    logic [5:0] lo;
    if (!rst_n) begin
      m_bc = 0; m_pc = 0; m_tc = 0; m_ctl = 8'h00; m_st = 7'h00; m_lv = 7'h00;
      m_larm = 1; m_sarm = 1; m_lp = 0; m_sp = 0; m_exp = 0;
    end else begin
      bt   = (m_bc == BAUD_DIV - 1);
      tt   = bt && (m_pc == TMR_DIV - 1);
      lreq = m_ctl[5] && m_larm;
      sreq = m_ctl[4] && m_sarm;
      lgo  = m_lp || lreq;
      sgo  = m_sp || sreq;
      lval = lreq ? host_preset : m_lv;
      ns   = m_st;
      if (bt) begin
        if (lgo) ns = lval;
        else if (sgo) begin
          if (adv_cond) ns = ref_next(m_st);
        end else if (!m_ctl[3] && !m_ctl[7]) begin
          if (deact || m_exp) ns = {m_st[6], 6'd0};
          else if (adv_cond) ns = ref_next(m_st);
        end
      end
      lo = m_st[5:0];
      if (sw_rst || m_ctl[2] || lo == 6'd0 || lo >= 6'(FIN)) begin
        m_tc = 0; m_exp = 0;
      end else if (tt && !m_exp) begin
        if (m_tc == TMO_TICKS - 1) begin m_exp = 1; m_tc = 0; end
        else m_tc++;
      end
      if (sw_rst) begin
        ns = 7'h00; m_ctl = 8'h00; m_larm = 1; m_sarm = 1; m_lp = 0; m_sp = 0; m_lv = 7'h00;
      end else begin
        m_larm = !m_ctl[5];
        m_sarm = !m_ctl[4];
        m_lp   = bt ? 1'b0 : (m_lp || lreq);
        m_sp   = bt ? 1'b0 : (m_sp || sreq);
        if (lreq) m_lv = host_preset;
        if (host_wr) m_ctl = host_wdata & 8'hFC;
      end
      m_st = ns;
      if (bt) m_pc = (m_pc == TMR_DIV - 1) ? 0 : m_pc + 1;
      m_bc = bt ? 0 : m_bc + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2_R3_R4_R5_R6_R8 state", 32'(act_state), 32'(m_st));
      chk("R7_R9 expire", 32'(tmr_expired), 32'(m_exp));
      chk("R10 read", 32'(rd_data), 32'(rd_sel ? m_ctl : monitor_in));
      chk("R11 interp", 32'(interp_en), 32'(m_ctl[7] & m_ctl[6] & lt_mode));
      chk("R12 baud", 32'(baud_tick), 32'(m_bc == BAUD_DIV - 1));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1;
    host_wr = 1'b1; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R1..: run did not complete");
    finish_run();
  end

  initial begin : main
    int nb;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    rd_sel = 1'b1;
    #1;
    chk("R1 reset state", 32'(act_state), 32'h0);
    chk("R1 reset expire", 32'(tmr_expired), 32'h0);
    chk("R1 reset ctl", 32'(rd_data), 32'h0);

    // autonomous run to final position
    cyc(1); adv_cond = 1'b1;
    cyc(36); @(negedge clk);
    chk("R5 R6 autonomous to final", 32'(act_state), 32'h45);
    cyc(1); adv_cond = 1'b0; deact = 1'b1;
    cyc(12); @(negedge clk);
    chk("R5 R6 deact keeps warm", 32'(act_state), 32'h40);
    cyc(1); deact = 1'b0;

    // timeout under steer, then fallback in autonomous mode
    host_preset = 7'h02;
    wr(8'hA0);
    cyc(60); @(negedge clk);
    chk("R7 expire set", 32'(tmr_expired), 32'h1);
    chk("R5 steer holds state", 32'(act_state), 32'h02);
    wr(8'h00);
    cyc(12); @(negedge clk);
    chk("R8 timeout to idle", 32'(act_state), 32'h00);
    chk("R7 expire cleared", 32'(tmr_expired), 32'h0);

    // timer disabled
    host_preset = 7'h03;
    wr(8'hA4);
    cyc(60); @(negedge clk);
    chk("R9 disabled expire", 32'(tmr_expired), 32'h0);
    chk("R2 load applied", 32'(act_state), 32'h03);

    // hold
    wr(8'h0C); adv_cond = 1'b1;
    cyc(20); @(negedge clk);
    chk("R4 hold freezes", 32'(act_state), 32'h03);

    // step
    wr(8'h1C);
    cyc(12); @(negedge clk);
    chk("R3 step once", 32'(act_state), 32'h04);
    cyc(12); @(negedge clk);
    chk("R3 held step no repeat", 32'(act_state), 32'h04);
    wr(8'h0C); adv_cond = 1'b0;
    wr(8'h1C);
    cyc(12); adv_cond = 1'b1;
    cyc(12); @(negedge clk);
    chk("R3 step dropped without cond", 32'(act_state), 32'h04);

    // load beats step
    wr(8'h0C); host_preset = 7'h11;
    wr(8'h3C);
    cyc(12); @(negedge clk);
    chk("R4 load over step", 32'(act_state), 32'h11);
    cyc(1); host_preset = 7'h22;
    cyc(12); @(negedge clk);
    chk("R2 held load no repeat", 32'(act_state), 32'h11);
    wr(8'h0C); wr(8'h2C);
    cyc(12); @(negedge clk);
    chk("R2 reload after clear", 32'(act_state), 32'h22);

    // read mux
    rd_sel = 1'b1; #1;
    chk("R10 ctl readback", 32'(rd_data), 32'h2C);
    cyc(1); rd_sel = 1'b0; monitor_in = 8'hA5; #1;
    chk("R10 monitor", 32'(rd_data), 32'hA5);

    // interpolator enable
    wr(8'hC4); lt_mode = 1'b1; #1;
    chk("R11 interp on", 32'(interp_en), 32'h1);
    cyc(1); lt_mode = 1'b0; #1;
    chk("R11 interp needs lt", 32'(interp_en), 32'h0);
    wr(8'h44); lt_mode = 1'b1; #1;
    chk("R11 interp needs steer", 32'(interp_en), 32'h0);
    wr(8'hFF); rd_sel = 1'b1; #1;
    chk("R10 reserved read zero", 32'(rd_data), 32'hFC);

    // baud strobe rate
    nb = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (baud_tick) nb++;
    end
    chk("R12 baud count", 32'(nb), 32'd10);

    // software reset
    cyc(1); adv_cond = 1'b0; sw_rst = 1'b1;
    cyc(1); sw_rst = 1'b0;
    @(negedge clk);
    chk("R1 sw reset state", 32'(act_state), 32'h0);
    chk("R1 sw reset ctl", 32'(rd_data), 32'h0);
    chk("R1 sw reset expire", 32'(tmr_expired), 32'h0);
    cyc(8);
    finish_run();
  end

endmodule